// File: doc/BRIEF.md
# Unlock-Gated Banked Indirect Register Access

This block is the register front end of a management register space, of the kind that sits in an Ethernet PHY. A host reaches it over a simple synchronous register bus. The bus carries an address, a write strobe with write data, and a read strobe with registered read data. Four directly addressed 16-bit registers are visible on the bus: a command register, two read-back registers and a write-data staging register. Behind them sit hidden banks of 32 internal 16-bit words.

The hidden banks stay sealed until the host writes a fixed four-word key to the command register. Once the banks are open, a single command-register write performs one indirect access. That word packs a direct read or write request, a 2-bit bank select, a test-mode enable, a 5-bit source index for reads and a 5-bit target index for writes. Bank 0 holds the analog/DSP words and bank 3 holds the built-in-self-test words. Banks 1 and 2 have no storage.

Top module: `tstbank_regfile`

## Requirements
- R1: After reset, all four direct registers read zero, read data is zero, the block is sealed, and every word of both implemented banks is zero.
- R2: The command register is at 0x14, the read-back registers at 0x15 and 0x16, and the staging register at 0x17. A read returns the addressed value on `bus_rdata` one cycle after `bus_rd`. Bus writes to 0x15, 0x16 and to any unmapped address have no effect, and unmapped addresses read zero.
- R3: The banks open only after four command-register writes in a row carrying 0x0000, 0x0400, 0x0000 and 0x0400. Writes to other addresses do not interrupt the key. A command write that breaks the key restarts tracking, and a breaking value of 0x0000 itself counts as the first key step.
- R4: While sealed, read and write commands have no effect on the banks or the read-back registers.
- R5: Once open, the banks stay open until reset or until a command write with bit 10 clear. A command write with bit 10 set keeps them open. The write that seals is not counted as a key step.
- R6: A command word with bit 14 set, bit 15 clear and bit 10 set copies the staging register into bank bits[12:11] at index bits[4:0].
- R7: A command word with bit 15 set, bit 14 clear and bit 10 set loads the word at bank bits[12:11], index bits[9:5] into read-back register 0x15 by the next cycle, and clears register 0x16.
- R8: A command word with both bit 15 and bit 14 set changes neither the banks nor the read-back registers.
- R9: Writes to banks 1 and 2 are dropped, and reads from them load zero.
- R10: Bank 0 and bank 3 hold 32 words each and are independent of each other; the same index in each bank holds its own value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register address for the current read or write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data, valid the cycle after `bus_rd` |

## Verification
A command write is acted on at the clock edge that takes it. The new read-back or bank content can therefore be fetched by a read strobe in the very next cycle, and that read value appears on `bus_rdata` one further edge later. The bench drives its inputs on falling edges. It advances a behavioural model at each rising edge, computing the read value from the state held before that edge's updates. It compares `bus_rdata` with the model on every falling edge, so each result is checked in exactly the cycle it is due. Directed reads then check fixed expected words for the key, sealing, bank-independence and ignored-command cases.

// File: rtl/tbk_pkg.sv
package tbk_pkg;
  localparam int WORD_W = 16;
  localparam int IDX_W  = 5;
  localparam int BSEL_W = 2;
  localparam int BIT_RD = 15;
  localparam int BIT_WR = 14;
  localparam int BIT_TM = 10;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE} op_e;

  function automatic logic [BSEL_W-1:0] f_bank(word_t w);
    return w[12:11];
  endfunction

  function automatic logic [IDX_W-1:0] f_src_idx(word_t w);
    return w[9:5];
  endfunction

  function automatic logic [IDX_W-1:0] f_dst_idx(word_t w);
    return w[4:0];
  endfunction

  // Operation requested by a command word; test mode must be set and
  // exactly one of the direction bits.
  function automatic op_e f_op(word_t w);
    if (!w[BIT_TM]) return OP_NONE;
    case ({w[BIT_RD], w[BIT_WR]})
      2'b10:   return OP_READ;
      2'b01:   return OP_WRITE;
      default: return OP_NONE;
    endcase
  endfunction

  // Expected key word at a given step of the unlock sequence.
  function automatic word_t f_key_word(int unsigned step);
    return step[0] ? 16'h0400 : 16'h0000;
  endfunction
endpackage

// File: rtl/tbk_unlock.sv
module tbk_unlock
  import tbk_pkg::*;
#(
  parameter int SEQ_LEN = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_we,
  input  word_t ctl_wdata,
  output logic  unlocked
);
  localparam int STEP_W = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0] step_q;
  logic              open_q;
  logic              key_match;
  logic              key_first;

  assign key_match = (ctl_wdata == f_key_word(int'(step_q)));
  assign key_first = (ctl_wdata == f_key_word(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      step_q <= '0;
    end else if (ctl_we) begin
      if (open_q) begin
        step_q <= '0;
        if (!ctl_wdata[BIT_TM]) open_q <= 1'b0;
      end else if (key_match) begin
        if (step_q == LAST) begin
          open_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end else begin
        step_q <= key_first ? STEP_W'(1) : '0;
      end
    end
  end

  assign unlocked = open_q;

  // R3: opening is always caused by a command write of the final key word
  p_open_on_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> ($past(ctl_we) && $past(ctl_wdata) == 16'h0400));
endmodule

// File: rtl/tbk_cmd_dec.sv
module tbk_cmd_dec
  import tbk_pkg::*;
(
  input  logic              ctl_we,
  input  logic              unlocked,
  input  word_t             cmd,
  output logic              rd_fire,
  output logic              wr_fire,
  output logic [BSEL_W-1:0] bank,
  output logic [IDX_W-1:0]  src_idx,
  output logic [IDX_W-1:0]  dst_idx
);
  op_e op;

  always_comb begin
    op      = f_op(cmd);
    rd_fire = ctl_we && unlocked && (op == OP_READ);
    wr_fire = ctl_we && unlocked && (op == OP_WRITE);
    bank    = f_bank(cmd);
    src_idx = f_src_idx(cmd);
    dst_idx = f_dst_idx(cmd);
  end
endmodule

// File: rtl/tbk_bank.sv
module tbk_bank
  import tbk_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  word_t                    wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output word_t                    rdata
);
  word_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R6: a store lands at the addressed word with the offered value
  p_store_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/tstbank_regfile.sv
module tstbank_regfile
  import tbk_pkg::*;
#(
  parameter int                 ADDR_W    = 5,
  parameter logic [ADDR_W-1:0]  A_CMD     = 5'h14,
  parameter logic [ADDR_W-1:0]  A_RB0     = 5'h15,
  parameter logic [ADDR_W-1:0]  A_RB1     = 5'h16,
  parameter logic [ADDR_W-1:0]  A_STAGE   = 5'h17,
  parameter int                 KEY_LEN   = 4,
  parameter logic [3:0]         IMPL_MASK = 4'b1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [15:0]       bus_rdata
);
  localparam int BANK_CNT = 1 << BSEL_W;
  localparam int DEPTH    = 1 << IDX_W;

  word_t cmd_q, rb0_q, rb1_q, stage_q, rdata_q;
  logic  cmd_we, stage_we;
  logic  unlocked;
  logic  rd_fire, wr_fire;
  logic [BSEL_W-1:0] sel_bank;
  logic [IDX_W-1:0]  src_idx, dst_idx;
  word_t bank_word [BANK_CNT];
  word_t rmux;

  assign cmd_we   = bus_wr && (bus_addr == A_CMD);
  assign stage_we = bus_wr && (bus_addr == A_STAGE);

  tbk_unlock #(.SEQ_LEN(KEY_LEN)) u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (cmd_we),
    .ctl_wdata (bus_wdata),
    .unlocked  (unlocked)
  );

  tbk_cmd_dec u_dec (
    .ctl_we   (cmd_we),
    .unlocked (unlocked),
    .cmd      (bus_wdata),
    .rd_fire  (rd_fire),
    .wr_fire  (wr_fire),
    .bank     (sel_bank),
    .src_idx  (src_idx),
    .dst_idx  (dst_idx)
  );

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    if (IMPL_MASK[b]) begin : g_impl
      tbk_bank #(.DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_fire && (sel_bank == BSEL_W'(b))),
        .waddr (dst_idx),
        .wdata (stage_q),
        .raddr (src_idx),
        .rdata (bank_word[b])
      );
    end else begin : g_empty
      assign bank_word[b] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      stage_q <= '0;
      rb0_q   <= '0;
      rb1_q   <= '0;
    end else begin
      if (cmd_we)   cmd_q   <= bus_wdata;
      if (stage_we) stage_q <= bus_wdata;
      if (rd_fire) begin
        rb0_q <= bank_word[sel_bank];
        rb1_q <= '0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CMD:   rmux = cmd_q;
      A_RB0:   rmux = rb0_q;
      A_RB1:   rmux = rb1_q;
      A_STAGE: rmux = stage_q;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rmux;
  end

  assign bus_rdata = rdata_q;

  // R4: no indirect access is issued while sealed
  p_sealed_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (!rd_fire && !wr_fire));

  // R5: a command write with test mode clear seals the banks
  p_reseal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && cmd_we && !bus_wdata[BIT_TM]) |=> !unlocked);

  // R8: both direction bits set issues nothing
  p_both_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && bus_wdata[BIT_RD] && bus_wdata[BIT_WR]) |-> (!rd_fire && !wr_fire));

  // R7: a read command leaves the second read-back register at zero
  p_rb1_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (rb1_q == '0));

  // R9: reading an empty bank loads zero
  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !IMPL_MASK[sel_bank]) |=> (rb0_q == '0));
endmodule

// File: tb/sim_tstbank_regfile.sv
module sim_tstbank_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tstbank_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  // Behavioural reference model
  int m_cmd, m_stage, m_rb0, m_rb1, m_rdata;
  int m_bank [4][32];
  bit m_open;
  int key_hist [$];

  function automatic bit has_storage(int b);
    return (b == 0) || (b == 3);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_stage = 0; m_rb0 = 0; m_rb1 = 0; m_rdata = 0;
      m_open = 0; key_hist.delete();
      for (int b = 0; b < 4; b++) for (int i = 0; i < 32; i++) m_bank[b][i] = 0;
    end else begin
      if (bus_rd) begin
        if (bus_addr == 5'h14) m_rdata = m_cmd;
        else if (bus_addr == 5'h15) m_rdata = m_rb0;
        else if (bus_addr == 5'h16) m_rdata = m_rb1;
        else if (bus_addr == 5'h17) m_rdata = m_stage;
        else m_rdata = 0;
      end
      if (bus_wr && bus_addr == 5'h14) begin
        bit was_open;
        int bk;
        was_open = m_open;
        m_cmd = bus_wdata;
        if (was_open) begin
          if (!bus_wdata[10]) m_open = 0;
        end else begin
          key_hist.push_back(int'(bus_wdata));
          if (key_hist.size() > 4) void'(key_hist.pop_front());
          if (key_hist.size() == 4 && key_hist[0] == 0 && key_hist[1] == 'h400 &&
              key_hist[2] == 0 && key_hist[3] == 'h400) begin
            m_open = 1;
            key_hist.delete();
          end
        end
        bk = int'(bus_wdata[12:11]);
        if (was_open && bus_wdata[10] && (bus_wdata[15] != bus_wdata[14])) begin
          if (bus_wdata[14]) begin
            if (has_storage(bk)) m_bank[bk][bus_wdata[4:0]] = m_stage;
          end else begin
            m_rb0 = has_storage(bk) ? m_bank[bk][bus_wdata[9:5]] : 0;
            m_rb1 = 0;
          end
        end
      end
      if (bus_wr && bus_addr == 5'h17) m_stage = bus_wdata;
    end
  end

  // Compare with the model on every cycle (R2 read timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(bus_rdata) != m_rdata) begin
        errors++;
        $display("FAIL R2 model compare: actual %h expected %h at %0t", bus_rdata, m_rdata[15:0], $time);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [4:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s: addr %h actual %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic unlock();
    wr(5'h14, 16'h0000); wr(5'h14, 16'h0400);
    wr(5'h14, 16'h0000); wr(5'h14, 16'h0400);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    rd_expect(5'h14, 16'h0000, "R1 cmd reset");
    rd_expect(5'h15, 16'h0000, "R1 rb0 reset");
    rd_expect(5'h16, 16'h0000, "R1 rb1 reset");
    rd_expect(5'h17, 16'h0000, "R1 stage reset");
    // R2: unmapped and read-only addresses
    wr(5'h03, 16'hABCD);
    rd_expect(5'h03, 16'h0000, "R2 unmapped");
    wr(5'h15, 16'h5555);
    rd_expect(5'h15, 16'h0000, "R2 rb0 read-only");
    // R4: write while sealed is dropped
    wr(5'h17, 16'h1234);
    wr(5'h14, 16'h4417);
    // R3: broken key does not open
    wr(5'h14, 16'h0000); wr(5'h14, 16'h0400); wr(5'h14, 16'h0400);
    wr(5'h14, 16'h0000); wr(5'h14, 16'h0400);
    wr(5'h14, 16'h86E0);
    rd_expect(5'h15, 16'h0000, "R3 broken key stays sealed");
    // R3: key with an interleaved staging write still opens
    wr(5'h14, 16'h0000); wr(5'h14, 16'h0400);
    wr(5'h17, 16'h8E0D);
    wr(5'h14, 16'h0000); wr(5'h14, 16'h0400);
    wr(5'h14, 16'h86E0);
    rd_expect(5'h15, 16'h0000, "R4 sealed write was dropped");
    rd_expect(5'h16, 16'h0000, "R7 rb1 cleared");
    // R6/R7: write then read bank 0 index 0x17
    wr(5'h14, 16'h4417);
    rd_expect(5'h14, 16'h4417, "R2 cmd readback");
    wr(5'h14, 16'h86E0);
    rd_expect(5'h15, 16'h8E0D, "R6 R7 bank0 write/read");
    // R10: bank 3 independent of bank 0
    wr(5'h17, 16'h0005);
    wr(5'h14, 16'h5C1B);
    wr(5'h14, 16'h9F60);
    rd_expect(5'h15, 16'h0005, "R10 bank3 index 0x1B");
    wr(5'h14, 16'h8760);
    rd_expect(5'h15, 16'h0000, "R10 bank0 index 0x1B untouched");
    // R9: bank 1 has no storage
    wr(5'h17, 16'hBEEF);
    wr(5'h14, 16'h4C05);
    wr(5'h14, 16'h86E0);
    wr(5'h14, 16'h8CA0);
    rd_expect(5'h15, 16'h0000, "R9 bank1 reads zero");
    wr(5'h14, 16'h9CA0);
    rd_expect(5'h15, 16'h0000, "R9 bank3 not aliased");
    // R8: both direction bits
    wr(5'h14, 16'h86E0);
    wr(5'h17, 16'h1111);
    wr(5'h14, 16'hC417);
    rd_expect(5'h15, 16'h8E0D, "R8 rb0 unchanged");
    wr(5'h14, 16'h86E0);
    rd_expect(5'h15, 16'h8E0D, "R8 bank unchanged");
    // R5: test-mode set keeps open, clear seals
    wr(5'h14, 16'h0417);
    wr(5'h17, 16'h2222);
    wr(5'h14, 16'h4417);
    wr(5'h14, 16'h86E0);
    rd_expect(5'h15, 16'h2222, "R5 stays open");
    wr(5'h14, 16'h0000);
    wr(5'h17, 16'h3333);
    wr(5'h14, 16'h4417);
    unlock();
    wr(5'h14, 16'h86E0);
    rd_expect(5'h15, 16'h2222, "R5 sealed after clear");
    // R1: reset clears banks
    do_reset();
    unlock();
    wr(5'h14, 16'h86E0);
    rd_expect(5'h15, 16'h0000, "R1 bank cleared by reset");
    // Mixed traffic checked against the model
    for (int n = 0; n < 2000; n++) begin
      int sel;
      logic [15:0] cw;
      sel = int'($urandom_range(0, 11));
      case ($urandom_range(0, 8))
        0: cw = 16'h0000; 1: cw = 16'h0400; 2: cw = 16'h4417;
        3: cw = 16'h5C1B; 4: cw = 16'h86E0; 5: cw = 16'h9F60;
        6: cw = 16'hC417; 7: cw = 16'h4C05;
        default: cw = 16'($urandom);
      endcase
      if (sel < 6) begin
        bus_addr = 5'h14; bus_wdata = cw; bus_wr = 1'b1; bus_rd = 1'b0;
      end else if (sel < 8) begin
        bus_addr = 5'h17; bus_wdata = 16'($urandom); bus_wr = 1'b1; bus_rd = 1'b0;
      end else begin
        bus_addr = 5'($urandom_range(16, 23)); bus_wr = 1'b0; bus_rd = 1'b1;
      end
      @(negedge clk);
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule